// File: doc/BRIEF.md
# I2C Register-Bank Target with Pointer Auto-Increment

This block is an I2C target that gives a bus host read and write access to a small bank of 16-bit registers addressed by a 16-bit pointer. The host addresses the target with a 7-bit device address. A write frame sends two pointer bytes, most significant first, followed by any number of two-byte data words. Each complete word is stored at the pointer, and the pointer then advances by one. A read frame streams words out from wherever the pointer currently stands. The pointer advances after each word that has been fully shifted out.

The pointer survives across frames. A host sets it with a short write frame, then issues a repeated start with the read bit set. Later read frames with no pointer phase pick up where the last access left off. The open-drain bus is modelled as sampled SCL and SDA inputs plus an SDA pull-down enable. Both lines are resynchronised into the system clock before edge and condition detection.

Top module: `i2c_regbank_target`

## Requirements
- R1: After reset the target does not pull SDA low, every register reads 0x0000 and the pointer is 0.
- R2: The first byte after a start holds the device address in bits 7:1 and the direction in bit 0 (0 = write, 1 = read). The target acknowledges a matching address. On a mismatch it gives no acknowledge, and it ignores every later byte, storing nothing, until the next start.
- R3: In a write frame the two bytes after the device address form the pointer, high byte first. The target acknowledges the device address, both pointer bytes and every data byte.
- R4: Data bytes pair into words, high byte first. When the low byte of a word arrives, the word is stored at the pointer and the pointer advances by one. Further words may follow without a stop.
- R5: A write frame that ends after the high byte of a word, with no low byte, leaves every register unchanged.
- R6: After a repeated start with the read bit, the target shifts out the high byte and then the low byte of the register at the pointer, MSB first. It keeps going with the next register for as long as the host acknowledges, and it releases SDA once the host answers a byte with NACK.
- R7: A read frame with no pointer phase continues from the pointer left by the previous frame. A completed read word advances the pointer exactly as a written word does.
- R8: A start or a stop ends the frame in progress. A pointer whose low byte was never received is not loaded, and the target leaves SDA released while the bus is idle.
- R9: Pointer values of 16 and above read as 0x0000, and writes to them change no register. The pointer itself is 16 bits wide and keeps counting past the bank.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Sampled level of the SCL line |
| sda_i | input | 1 | Sampled level of the SDA line |
| sda_oe | output | 1 | 1 pulls SDA low; 0 releases it |

## Verification
The bench drives the bus bit by bit and checks the register data it reads back against its own model of the bank and the pointer. Multi-word writes followed by addressed reads show that bytes pair high-first and that the pointer advances once per word. Follow-up reads with no pointer phase show that the pointer persists across frames. A frame with the wrong device address, a frame that stops after one pointer byte, and a frame with an odd number of data bytes each check that an incomplete or foreign frame changes nothing. Writes at pointer values 15, 16 and 0x8003 separate correct range decoding from index aliasing.

// File: rtl/i2cr_pkg.sv
// Shared definitions for the I2C register-bank target.
// Assumes 16-bit pointers and 16-bit words carried as byte pairs.
package i2cr_pkg;
    localparam int PTR_W  = 16;
    localparam int WORD_W = 16;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RX,
        ST_ACK,
        ST_TX,
        ST_MACK,
        ST_IGNORE
    } state_e;

    typedef enum logic [2:0] {
        PH_DEV,
        PH_PHI,
        PH_PLO,
        PH_WHI,
        PH_WLO
    } phase_e;
endpackage

// File: rtl/i2cr_sync.sv
// Resynchronises SCL and SDA into clk and derives SCL edges plus
// start/stop conditions (SDA edges seen while SCL stays high).
// Assumes both lines idle high; reset loads the chain with ones.
module i2cr_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic [STAGES-1:0] scl_pipe;
    logic [STAGES-1:0] sda_pipe;
    logic              scl_q;
    logic              sda_q;

    // Shift both lines through the synchroniser chain, keep one old copy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
            scl_q    <= 1'b1;
            sda_q    <= 1'b1;
        end else begin
            scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
            sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
            scl_q    <= scl_pipe[STAGES-1];
            sda_q    <= sda_pipe[STAGES-1];
        end
    end

    // Edge and bus-condition decode from the settled samples.
    always_comb begin
        scl_s     = scl_pipe[STAGES-1];
        sda_s     = sda_pipe[STAGES-1];
        scl_rise  = scl_s & ~scl_q;
        scl_fall  = ~scl_s & scl_q;
        start_det = scl_s & scl_q & sda_q & ~sda_s;
        stop_det  = scl_s & scl_q & ~sda_q & sda_s;
    end
endmodule

// File: rtl/i2cr_regfile.sv
// Register bank: synchronous write, combinational read.
// Assumes any address with bits set above the index range is outside
// the bank: such reads return zero and such writes are dropped.
module i2cr_regfile #(
    parameter int DEPTH  = 16,
    parameter int ADDR_W = 16,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    localparam int IDX_W = $clog2(DEPTH);

    logic [DEPTH-1:0][DATA_W-1:0] mem;
    logic                         in_range;

    // Range decode of the shared address.
    always_comb begin
        in_range = (addr[ADDR_W-1:IDX_W] == '0) && (int'(addr[IDX_W-1:0]) < DEPTH);
        rdata    = in_range ? mem[addr[IDX_W-1:0]] : '0;
    end

    // Store one word per write strobe into the indexed entry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem <= '0;
        end else begin
            for (int i = 0; i < DEPTH; i++) begin
                if (we && in_range && (int'(addr[IDX_W-1:0]) == i)) begin
                    mem[i] <= wdata;
                end
            end
        end
    end

    // R9: a write outside the bank leaves every entry untouched.
    assert_no_oor_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (we && (addr >= ADDR_W'(DEPTH))) |=> $stable(mem));
endmodule

// File: rtl/i2cr_engine.sv
// Byte-level I2C target engine: device-address match, pointer load,
// word assembly with commit on the low byte, and word streaming on reads.
// Assumes synchronised SCL edges and start/stop pulses from i2cr_sync,
// and a register bank with combinational read at the pointer.
module i2cr_engine
    import i2cr_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'h2A
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_lvl,
    input  logic              sda_s,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_det,
    input  logic              stop_det,
    output logic              sda_oe,
    output logic              reg_we,
    output logic [PTR_W-1:0]  reg_addr,
    output logic [WORD_W-1:0] reg_wdata,
    input  logic [WORD_W-1:0] reg_rdata
);
    state_e             state;
    phase_e             phase;
    logic [3:0]         bitcnt;
    logic [7:0]         shreg;
    logic [7:0]         ptr_hi;
    logic [7:0]         word_hi;
    logic [PTR_W-1:0]   ptr;
    logic               rd_mode;
    logic               low_sel;
    logic               host_nack;
    logic               byte_end;

    // Byte boundary on the receive side and the commit strobe.
    always_comb begin
        byte_end  = (state == ST_RX) && scl_fall && (bitcnt == 4'd8);
        reg_we    = byte_end && (phase == PH_WLO) && !rd_mode;
        reg_addr  = ptr;
        reg_wdata = {word_hi, shreg};
        sda_oe    = (state == ST_ACK) || ((state == ST_TX) && !shreg[7]);
    end

    // Frame sequencer: bus conditions first, then per-state bit handling.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            phase     <= PH_DEV;
            bitcnt    <= '0;
            shreg     <= '0;
            ptr_hi    <= '0;
            word_hi   <= '0;
            ptr       <= '0;
            rd_mode   <= 1'b0;
            low_sel   <= 1'b0;
            host_nack <= 1'b0;
        end else if (start_det) begin
            state   <= ST_RX;
            phase   <= PH_DEV;
            bitcnt  <= '0;
            rd_mode <= 1'b0;
        end else if (stop_det) begin
            state <= ST_IDLE;
        end else begin
            case (state)
                ST_RX: begin
                    if (scl_rise) begin
                        shreg  <= {shreg[6:0], sda_s};
                        bitcnt <= bitcnt + 4'd1;
                    end else if (byte_end) begin
                        bitcnt <= '0;
                        state  <= ST_ACK;
                        case (phase)
                            PH_DEV: begin
                                if (shreg[7:1] == DEV_ADDR) begin
                                    rd_mode <= shreg[0];
                                    if (!shreg[0]) phase <= PH_PHI;
                                end else begin
                                    state <= ST_IGNORE;
                                end
                            end
                            PH_PHI: begin
                                ptr_hi <= shreg;
                                phase  <= PH_PLO;
                            end
                            PH_PLO: begin
                                ptr   <= {ptr_hi, shreg};
                                phase <= PH_WHI;
                            end
                            PH_WHI: begin
                                word_hi <= shreg;
                                phase   <= PH_WLO;
                            end
                            default: begin
                                ptr   <= ptr + PTR_W'(1);
                                phase <= PH_WHI;
                            end
                        endcase
                    end
                end
                ST_ACK: begin
                    if (scl_fall) begin
                        bitcnt <= '0;
                        if (rd_mode) begin
                            shreg   <= reg_rdata[15:8];
                            low_sel <= 1'b0;
                            state   <= ST_TX;
                        end else begin
                            state <= ST_RX;
                        end
                    end
                end
                ST_TX: begin
                    if (scl_rise) begin
                        bitcnt <= bitcnt + 4'd1;
                    end else if (scl_fall) begin
                        if (bitcnt == 4'd8) begin
                            state <= ST_MACK;
                            if (low_sel) ptr <= ptr + PTR_W'(1);
                        end else begin
                            shreg <= {shreg[6:0], 1'b0};
                        end
                    end
                end
                ST_MACK: begin
                    if (scl_rise) begin
                        host_nack <= sda_s;
                    end else if (scl_fall) begin
                        if (host_nack) begin
                            state <= ST_IGNORE;
                        end else begin
                            bitcnt  <= '0;
                            state   <= ST_TX;
                            low_sel <= !low_sel;
                            shreg   <= low_sel ? reg_rdata[15:8] : reg_rdata[7:0];
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    // R4: every stored word moves the pointer on by exactly one.
    assert_ptr_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |=> (ptr == $past(ptr) + PTR_W'(1)));

    // R7: a new frame never disturbs the pointer by itself.
    assert_ptr_hold_start_R7: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> (ptr == $past(ptr)));

    // R6: SDA drive changes only while SCL is low (or at a bus condition).
    assert_oe_quiet_scl_high_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(scl_lvl) && scl_lvl && !$past(start_det) && !$past(stop_det))
        |-> $stable(sda_oe));
endmodule

// File: rtl/i2c_regbank_target.sv
// Top level: synchroniser, target engine and register bank.
// Assumes open-drain bus: sda_oe=1 pulls SDA low, never drives high.
module i2c_regbank_target
    import i2cr_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR    = 7'h2A,
    parameter int         DEPTH       = 16,
    parameter int         SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_oe
);
    logic              scl_s;
    logic              sda_s;
    logic              scl_rise;
    logic              scl_fall;
    logic              start_det;
    logic              stop_det;
    logic              reg_we;
    logic [PTR_W-1:0]  reg_addr;
    logic [WORD_W-1:0] reg_wdata;
    logic [WORD_W-1:0] reg_rdata;

    i2cr_sync #(.STAGES(SYNC_STAGES)) sync_i (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det)
    );

    i2cr_engine #(.DEV_ADDR(DEV_ADDR)) engine_i (
        .clk(clk), .rst_n(rst_n), .scl_lvl(scl_s), .sda_s(sda_s),
        .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det), .sda_oe(sda_oe),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata)
    );

    i2cr_regfile #(.DEPTH(DEPTH), .ADDR_W(PTR_W), .DATA_W(WORD_W)) bank_i (
        .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr),
        .wdata(reg_wdata), .rdata(reg_rdata)
    );
endmodule

// File: tb/i2c_regbank_target_tb_top.sv
// Bench: bit-level bus host plus a behavioural model of the bank and pointer.
module i2c_regbank_target_tb_top;
    localparam logic [6:0] DEV = 7'h2A;
    localparam int         Q   = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic sda_oe;
    logic sda_line;

    assign sda_line = sda_m & ~sda_oe;
    always #4 clk = ~clk;

    i2c_regbank_target #(.DEV_ADDR(DEV)) dut_i (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line), .sda_oe(sda_oe)
    );

    int compared   = 0;
    int mismatched = 0;
    int model [16];
    int mptr       = 0;
    int wbuf  [8];
    bit bus_idle   = 1'b0;
    bit done       = 1'b0;

    task automatic chk(input string tag, input int act, input int exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic int model_rd(input int a);
        return (a < 16) ? model[a] : 0;
    endfunction

    // R8: while the bus is idle the target must keep SDA released.
    always @(negedge clk) begin
        if (bus_idle && rst_n) chk("R8 idle release", int'(sda_oe), 0);
    end

    task automatic qw();
        repeat (Q) @(negedge clk);
    endtask

    task automatic bus_start();
        bus_idle = 1'b0;
        sda_m = 1'b1; qw();
        scl_m = 1'b1; qw();
        sda_m = 1'b0; qw();
        scl_m = 1'b0; qw();
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; qw();
        scl_m = 1'b1; qw();
        sda_m = 1'b1; qw(); qw();
        bus_idle = 1'b1;
    endtask

    task automatic put_bit(input logic b);
        sda_m = b; qw();
        scl_m = 1'b1; qw(); qw();
        scl_m = 1'b0; qw();
    endtask

    task automatic get_bit(output logic b);
        sda_m = 1'b1; qw();
        scl_m = 1'b1; qw();
        b = sda_line; qw();
        scl_m = 1'b0; qw();
    endtask

    task automatic send_byte(input logic [7:0] v, output bit ack);
        logic b;
        for (int i = 7; i >= 0; i--) put_bit(v[i]);
        get_bit(b);
        ack = !b;
    endtask

    task automatic recv_byte(output logic [7:0] v, input bit ack);
        logic b;
        for (int i = 7; i >= 0; i--) begin
            get_bit(b);
            v[i] = b;
        end
        put_bit(!ack);
    endtask

    task automatic send_chk(input logic [7:0] v, input int exp_ack, input string tag);
        bit a;
        send_byte(v, a);
        chk(tag, int'(a), exp_ack);
    endtask

    // R3/R4: pointer phase then n words from wbuf, optional lone high byte.
    task automatic write_seq(input int addr, input int n, input bit extra,
                             input logic [7:0] xb, input string tag);
        int a;
        bus_start();
        send_chk({DEV, 1'b0}, 1, {tag, " dev ack"});
        send_chk(8'((addr >> 8) & 8'hFF), 1, {tag, " ptr hi ack"});
        send_chk(8'(addr & 8'hFF), 1, {tag, " ptr lo ack"});
        a = addr;
        for (int k = 0; k < n; k++) begin
            send_chk(8'((wbuf[k] >> 8) & 8'hFF), 1, {tag, " data hi ack"});
            send_chk(8'(wbuf[k] & 8'hFF), 1, {tag, " data lo ack"});
            if (a < 16) model[a] = wbuf[k];
            a = (a + 1) & 16'hFFFF;
        end
        if (extra) send_chk(xb, 1, {tag, " odd byte ack"});
        bus_stop();
        mptr = a;
    endtask

    task automatic read_words(input int n, input string tag);
        logic [7:0] hi;
        logic [7:0] lo;
        for (int k = 0; k < n; k++) begin
            recv_byte(hi, 1'b1);
            recv_byte(lo, k != n - 1);
            chk(tag, int'({hi, lo}), model_rd(mptr));
            mptr = (mptr + 1) & 16'hFFFF;
        end
    endtask

    // R6: pointer phase, repeated start, then streamed read.
    task automatic addr_read(input int addr, input int n, input string tag);
        bus_start();
        send_chk({DEV, 1'b0}, 1, {tag, " dev ack"});
        send_chk(8'((addr >> 8) & 8'hFF), 1, {tag, " ptr hi ack"});
        send_chk(8'(addr & 8'hFF), 1, {tag, " ptr lo ack"});
        bus_start();
        send_chk({DEV, 1'b1}, 1, {tag, " dev rd ack"});
        mptr = addr;
        read_words(n, tag);
        bus_stop();
    endtask

    // R7: read frame with no pointer phase.
    task automatic cont_read(input int n, input string tag);
        bus_start();
        send_chk({DEV, 1'b1}, 1, {tag, " dev rd ack"});
        read_words(n, tag);
        bus_stop();
    endtask

    task automatic report();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    endtask

    initial begin
        for (int i = 0; i < 16; i++) model[i] = 0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 sda released after reset", int'(sda_oe), 0);
        bus_idle = 1'b1;
        qw();

        // R1: bank is cleared
        addr_read(0, 2, "R1 reset read");

        // R3 R4: multi-word write without stop
        wbuf[0] = 16'hA1B2; wbuf[1] = 16'hC3D4; wbuf[2] = 16'hE5F6; wbuf[3] = 16'h0789;
        write_seq(2, 4, 1'b0, 8'h00, "R4 burst write");
        addr_read(2, 2, "R6 addressed read");
        cont_read(2, "R7 continued read");

        // R2: foreign device address is ignored until the next start
        bus_start();
        send_chk({DEV ^ 7'h01, 1'b0}, 0, "R2 foreign addr nack");
        send_chk(8'h00, 0, "R2 ignored ptr hi");
        send_chk(8'h05, 0, "R2 ignored ptr lo");
        send_chk(8'h11, 0, "R2 ignored data hi");
        send_chk(8'h22, 0, "R2 ignored data lo");
        bus_stop();
        addr_read(5, 1, "R2 reg5 unchanged");

        // R8: stop after only the pointer high byte keeps the old pointer
        wbuf[0] = 16'h5A5A;
        write_seq(12, 1, 1'b0, 8'h00, "R4 single write");
        addr_read(11, 1, "R8 setup read");
        bus_start();
        send_chk({DEV, 1'b0}, 1, "R8 dev ack");
        send_chk(8'h00, 1, "R8 lone ptr hi ack");
        bus_stop();
        cont_read(1, "R8 pointer kept");

        // R5: odd byte count does not store a partial word
        wbuf[0] = 16'h1357;
        write_seq(9, 1, 1'b1, 8'hAB, "R5 odd write");
        addr_read(9, 2, "R5 no partial commit");

        // R9: out-of-range writes dropped, reads zero
        wbuf[0] = 16'h1234;
        write_seq(16'h0010, 1, 1'b0, 8'h00, "R9 write at 16");
        wbuf[0] = 16'h4321;
        write_seq(16'h8003, 1, 1'b0, 8'h00, "R9 write at 8003");
        addr_read(16'h0010, 1, "R9 read at 16");
        addr_read(0, 1, "R9 reg0 not aliased");
        addr_read(3, 1, "R9 reg3 not aliased");
        wbuf[0] = 16'hBEEF; wbuf[1] = 16'hCAFE;
        write_seq(15, 2, 1'b0, 8'h00, "R9 write across top");
        addr_read(14, 3, "R9 read across top");

        done = 1'b1;
        report();
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            mismatched++;
            $display("FAIL watchdog: actual timeout expected completion");
            report();
        end
    end
endmodule